// File: doc/BRIEF.md
# PWM Output Fault Override Stage

This block sits between a multi-channel PWM waveform generator and the pins. In normal operation it passes each raw waveform bit to its pin, inverted or not per channel, with every output enable asserted. Two fault event inputs each pass through a synchronizer and a programmable pulse-width filter of their own. A fault that survives its filter moves the block into a non-recoverable fault state. In that state every channel either drives a programmed level or is tri-stated, and a per-channel enable picks which.

A fault input whose filter value is zero bypasses qualification. The raw level overrides the pins combinationally, with no clock edge needed, and it is also latched through the synchronizer. The latched state holds until a clear pulse arrives or the block is disabled. All configuration arrives on one flat control word that is held by an external register file. That word may only change while the block is disabled.

Top module: `pwm_fault_stage`

## Requirements
- R1: Control word layout at the default sizes: bits 7:0 are per-channel override enables, bits 15:8 are per-channel fault levels, bits 23:16 are per-channel invert enables, bits 27:24 are the filter value of fault input 0, and bits 31:28 are the filter value of fault input 1.
- R2: After reset, with no fault seen, every `pin_oe` bit is 1 and `pin_val` equals `wave_in` passed through the invert enables.
- R3: Outside the fault state, a channel whose invert enable is 1 drives the complement of its waveform bit, and one whose invert enable is 0 drives the bit unchanged.
- R4: With a filter value F greater than 0, a fault pulse that is high for fewer than F consecutive sampling edges never enters the fault state.
- R5: With a filter value F, a fault input that is high at rising edges k through k+F-1 sets the fault state at edge k+F+1. That edge count includes the two synchronizer stages.
- R6: With a filter value of 0, a high fault input overrides the outputs combinationally, before any clock edge.
- R7: In the fault state, a channel whose override enable is 1 has `pin_oe` = 1 and drives its fault level exactly as programmed, with no inversion.
- R8: In the fault state, a channel whose override enable is 0 has `pin_oe` = 0 and `pin_val` = 0.
- R9: Once set, the fault state persists while the block is enabled and no clear is given, even after the fault input returns low.
- R10: A high `fault_clr` at a rising edge leaves the fault state cleared after that edge. It takes priority over a fault that qualifies at the same edge.
- R11: While `enable` is low, no fault state is held and the fault inputs have no effect on the outputs.
- R12: Each fault input is filtered independently, using its own filter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which is also the filter time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; when low, clears the fault state and the filters |
| fault_clr | input | 1 | Synchronous pulse that releases the fault state |
| wave_in | input | 8 | Raw waveform bits from the generator |
| fault_in | input | 2 | Fault event inputs, active high |
| ctrl_word | input | 32 | Filter values, invert enables, fault levels and override enables |
| pin_val | output | 8 | Output level per channel |
| pin_oe | output | 8 | Output enable per channel; 0 means tri-state |

## Verification
The properties assume that `ctrl_word` holds steady while `enable` is high. This matters because the override and tri-state checks compare the pins against the fields that are current at the same edge. To stay within that assumption, the stimulus drops `enable` for a cycle each time it loads a new word. It then raises `enable` again only when both fault inputs are low. The random fault bursts, waveforms and clear pulses change only on falling clock edges. As a result, each sampled edge sees stable inputs, and the combinational zero-filter path is checked between edges.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;

   // how one channel drives its pin in the current cycle
   typedef enum logic [1:0] {
      DRV_WAVE  = 2'd0,
      DRV_LEVEL = 2'd1,
      DRV_HIZ   = 2'd2
   } drv_mode_e;

   function automatic drv_mode_e pick_mode(input logic fault_act, input logic ovr_en);
      if (!fault_act)  return DRV_WAVE;
      else if (ovr_en) return DRV_LEVEL;
      else             return DRV_HIZ;
   endfunction

endpackage

// File: rtl/pwm_ovr_filter.sv
module pwm_ovr_filter #(
   parameter int FV_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            raw,
   input  logic [FV_W-1:0] fv,
   output logic            qualify,
   output logic            async_hit
);

   localparam logic [FV_W-1:0] CNT_MAX = {FV_W{1'b1}};

   logic            lvl;
   logic [FV_W-1:0] run_cnt;
   logic [FV_W:0]   run_next;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("pwm_ovr_filter: SYNC_STAGES must be at least 1");
      end
      if (FV_W < 1) begin : g_bad_w
         $error("pwm_ovr_filter: FV_W must be at least 1");
      end

      if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= raw;
         end
         assign lvl = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[SYNC_STAGES-2:0], raw};
         end
         assign lvl = s_q[SYNC_STAGES-1];
      end
   endgenerate

   // consecutive-high run length, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_cnt <= '0;
      else if (!enable || !lvl)  run_cnt <= '0;
      else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
   end

   assign run_next  = {1'b0, run_cnt} + 1'b1;
   assign qualify   = enable & lvl & (run_next >= {1'b0, fv});
   assign async_hit = enable & raw & (fv == '0);

endmodule

// File: rtl/pwm_ovr_chan.sv
module pwm_ovr_chan
   import pwm_ovr_pkg::*;
(
   input  logic wave,
   input  logic inv,
   input  logic lvl,
   input  logic ovr_en,
   input  logic fault_act,
   output logic pin_val,
   output logic pin_oe
);

   drv_mode_e mode;

   always_comb begin
      mode = pick_mode(fault_act, ovr_en);
      unique case (mode)
         DRV_WAVE:  begin pin_val = wave ^ inv; pin_oe = 1'b1; end
         DRV_LEVEL: begin pin_val = lvl;        pin_oe = 1'b1; end
         default:   begin pin_val = 1'b0;       pin_oe = 1'b0; end
      endcase
   end

endmodule

// File: rtl/pwm_fault_stage.sv
module pwm_fault_stage #(
   parameter int NUM_CH      = 8,
   parameter int NUM_FLT     = 2,
   parameter int FV_W        = 4,
   parameter int SYNC_STAGES = 2,
   localparam int CTRL_W     = 3 * NUM_CH + NUM_FLT * FV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              fault_clr,
   input  logic [NUM_CH-1:0] wave_in,
   input  logic [NUM_FLT-1:0] fault_in,
   input  logic [CTRL_W-1:0] ctrl_word,
   output logic [NUM_CH-1:0] pin_val,
   output logic [NUM_CH-1:0] pin_oe
);

   localparam int EN_LSB  = 0;
   localparam int LVL_LSB = NUM_CH;
   localparam int INV_LSB = 2 * NUM_CH;
   localparam int FV_LSB  = 3 * NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_FLT < 1) begin : g_bad_cfg
         $error("pwm_fault_stage: need at least one channel and one fault input");
      end
   endgenerate

   logic [NUM_CH-1:0]  ovr_en, flt_lvl, inv_en;
   logic [NUM_FLT-1:0] qual, async_hit;
   logic               fault_lat, fault_act;

   assign ovr_en  = ctrl_word[EN_LSB  +: NUM_CH];
   assign flt_lvl = ctrl_word[LVL_LSB +: NUM_CH];
   assign inv_en  = ctrl_word[INV_LSB +: NUM_CH];

   generate
      for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
         pwm_ovr_filter #(
            .FV_W        (FV_W),
            .SYNC_STAGES (SYNC_STAGES)
         ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (enable),
            .raw       (fault_in[f]),
            .fv        (ctrl_word[FV_LSB + f*FV_W +: FV_W]),
            .qualify   (qual[f]),
            .async_hit (async_hit[f])
         );
      end
   endgenerate

   // non-recoverable state: clear and disable win over a new qualification
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    fault_lat <= 1'b0;
      else if (!enable || fault_clr) fault_lat <= 1'b0;
      else if (|qual)                fault_lat <= 1'b1;
   end

   assign fault_act = fault_lat | (|async_hit);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pwm_ovr_chan u_chan (
            .wave      (wave_in[c]),
            .inv       (inv_en[c]),
            .lvl       (flt_lvl[c]),
            .ovr_en    (ovr_en[c]),
            .fault_act (fault_act),
            .pin_val   (pin_val[c]),
            .pin_oe    (pin_oe[c])
         );
      end
   endgenerate

endmodule

// File: rtl/pwm_fault_stage_chk.sv
module pwm_fault_stage_chk #(
   parameter int NUM_CH = 8,
   parameter int CTRL_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              fault_clr,
   input logic [NUM_CH-1:0] wave_in,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic [NUM_CH-1:0] pin_val,
   input logic [NUM_CH-1:0] pin_oe,
   input logic              fault_lat,
   input logic              fault_act
);

   logic [NUM_CH-1:0] en_f, lvl_f, inv_f;
   assign en_f  = ctrl_word[0 +: NUM_CH];
   assign lvl_f = ctrl_word[NUM_CH +: NUM_CH];
   assign inv_f = ctrl_word[2*NUM_CH +: NUM_CH];

   // R3
   normal_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_act |-> (pin_oe == {NUM_CH{1'b1}}) && (pin_val == (wave_in ^ inv_f)));

   // R7
   override_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_act |-> ((pin_val & en_f) == (lvl_f & en_f)));

   // R8
   tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_act |-> (pin_oe == en_f) && ((pin_val & ~en_f) == '0));

   // R9
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_lat && enable && !fault_clr |=> fault_lat);

   // R10
   clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr |=> !fault_lat);

   // R11
   disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !fault_lat);

   // R11
   disabled_no_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable && !fault_lat |-> (pin_oe == {NUM_CH{1'b1}}));

endmodule

bind pwm_fault_stage pwm_fault_stage_chk #(
   .NUM_CH (NUM_CH),
   .CTRL_W (CTRL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .fault_clr (fault_clr),
   .wave_in   (wave_in),
   .ctrl_word (ctrl_word),
   .pin_val   (pin_val),
   .pin_oe    (pin_oe),
   .fault_lat (fault_lat),
   .fault_act (fault_act)
);

// File: tb/sim_pwm_fault_stage.sv
`timescale 1ns/1ps
module sim_pwm_fault_stage;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        fault_clr = 1'b0;
   logic [7:0]  wave_in = '0;
   logic [1:0]  fault_in = '0;
   logic [31:0] ctrl_word = '0;
   logic [7:0]  pin_val, pin_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pwm_fault_stage u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fault_clr(fault_clr),
      .wave_in(wave_in), .fault_in(fault_in), .ctrl_word(ctrl_word),
      .pin_val(pin_val), .pin_oe(pin_oe)
   );

   // ---- reference model written from the requirements ----
   logic [1:0] ms1, ms2;
   logic [3:0] mc0, mc1;
   logic       m_lat;

   always @(posedge clk or negedge rst_n) begin : model
      logic q;
      q = 1'b0;
      if (!rst_n) begin
         ms1 <= '0; ms2 <= '0; mc0 <= '0; mc1 <= '0; m_lat <= 1'b0;
      end else begin
         ms1 <= fault_in;
         ms2 <= ms1;
         mc0 <= (!enable || !ms2[0]) ? 4'd0 : (mc0 == 4'd15 ? mc0 : mc0 + 4'd1);
         mc1 <= (!enable || !ms2[1]) ? 4'd0 : (mc1 == 4'd15 ? mc1 : mc1 + 4'd1);
         q = enable && ((ms2[0] && ({1'b0, mc0} + 5'd1 >= {1'b0, ctrl_word[27:24]})) ||
                        (ms2[1] && ({1'b0, mc1} + 5'd1 >= {1'b0, ctrl_word[31:28]})));
         m_lat <= (!enable || fault_clr) ? 1'b0 : (q ? 1'b1 : m_lat);
      end
   end

   function automatic logic [15:0] exp_pins(input logic flt, input logic [7:0] w,
                                            input logic [31:0] c);
      if (flt) return {c[15:8] & c[7:0], c[7:0]};
      else     return {w ^ c[23:16], 8'hFF};
   endfunction

   function automatic logic model_flt();
      return m_lat | (enable & ((fault_in[0] & (ctrl_word[27:24] == 4'd0)) |
                                (fault_in[1] & (ctrl_word[31:28] == 4'd0))));
   endfunction

   task automatic chk(input string tag, input logic flt);
      logic [15:0] e;
      e = exp_pins(flt, wave_in, ctrl_word);
      n_chk++;
      if (pin_val !== e[15:8] || pin_oe !== e[7:0]) begin
         n_fail++;
         $display("FAIL %s: val=%h oe=%h expected val=%h oe=%h",
                  tag, pin_val, pin_oe, e[15:8], e[7:0]);
      end
   endtask

   task automatic load_ctrl(input logic [31:0] c);
      @(negedge clk);
      enable = 1'b0;
      ctrl_word = c;
      @(negedge clk);
      enable = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      finish_run();
   end

   initial begin
      int b0, b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset state, pass-through with zero control word
      @(negedge clk);
      wave_in = 8'hA5;
      #1 chk("R2 reset pass-through", 1'b0);

      // R3: inversion of low nibble
      load_ctrl(32'h000F_0000);
      @(negedge clk);
      wave_in = 8'h33;
      #1 chk("R3 invert low nibble", 1'b0);

      // R11: disabled, zero filter, fault high -> no effect
      load_ctrl(32'h0000_F0A0);
      @(negedge clk);
      enable = 1'b0;
      fault_in = 2'b01;
      repeat (4) begin
         @(negedge clk);
         #1 chk("R11 disabled ignores fault", 1'b0);
      end
      fault_in = 2'b00;
      repeat (3) @(negedge clk);

      // R6/R7/R8/R1: async path, override bits 7:4 level A, low bits tri-state, inversion on
      load_ctrl(32'h00FF_A0F0);
      @(negedge clk);
      wave_in = 8'h5C;
      fault_in = 2'b01;
      #1 chk("R6 async override before any edge", 1'b1);
      if (pin_oe !== 8'hF0 || pin_val !== 8'hA0) begin
         n_fail++;
         $display("FAIL R1/R7/R8 field use: val=%h oe=%h expected val=a0 oe=f0", pin_val, pin_oe);
      end
      n_chk++;
      repeat (4) @(negedge clk);
      fault_in = 2'b00;
      repeat (3) begin
         @(negedge clk);
         #1 chk("R9 latched after fault drops", 1'b1);
      end

      // R10: clear pulse releases
      fault_clr = 1'b1;
      @(negedge clk);
      fault_clr = 1'b0;
      #1 chk("R10 clear releases", 1'b0);

      // R4/R12: fault1 with filter 5, held 4 edges -> rejected
      load_ctrl(32'h5300_FF0F);
      @(negedge clk);
      fault_in = 2'b10;
      for (int j = 1; j <= 9; j++) begin
         @(negedge clk);
         if (j == 4) fault_in = 2'b00;
         #1 chk("R4 short pulse rejected (R12 filter 1 value)", 1'b0);
      end

      // R4: fault0 with filter 3, held 2 edges -> rejected
      @(negedge clk);
      fault_in = 2'b01;
      for (int j = 1; j <= 7; j++) begin
         @(negedge clk);
         if (j == 2) fault_in = 2'b00;
         #1 chk("R4 two-edge pulse with filter 3", 1'b0);
      end

      // R5: fault0 held exactly 3 edges with filter 3 -> latch after edge 5
      @(negedge clk);
      fault_in = 2'b01;
      for (int j = 1; j <= 7; j++) begin
         @(negedge clk);
         if (j == 3) fault_in = 2'b00;
         #1 chk(j < 5 ? "R5 not yet qualified" : "R5 qualified at edge k+F+1", j >= 5);
      end

      // R10: clear wins over a simultaneous qualification (filter 1, held)
      load_ctrl(32'h0100_00FF);
      @(negedge clk);
      fault_in = 2'b01;
      repeat (6) @(negedge clk);
      fault_clr = 1'b1;
      @(negedge clk);
      fault_clr = 1'b0;
      #1 chk("R10 clear priority at the clear edge", 1'b0);
      @(negedge clk);
      #1 chk("R9 re-qualifies while held", 1'b1);
      fault_in = 2'b00;

      // random phase
      void'($urandom(32'd1234));
      b0 = 0; b1 = 0;
      load_ctrl(32'h2100_3CC3);
      for (int i = 0; i < 4000; i++) begin
         if (i % 400 == 399) begin
            fault_in = 2'b00;
            b0 = 0; b1 = 0;
            repeat (4) @(negedge clk);
            load_ctrl({1'b0, 3'($urandom_range(0, 4)), 1'b0, 3'($urandom_range(0, 4)),
                       24'($urandom)});
         end
         @(negedge clk);
         wave_in = 8'($urandom);
         fault_clr = ($urandom_range(0, 39) == 0);
         if (b0 > 0) b0--; else if ($urandom_range(0, 24) == 0) b0 = $urandom_range(1, 6);
         if (b1 > 0) b1--; else if ($urandom_range(0, 24) == 0) b1 = $urandom_range(1, 6);
         fault_in = {b1 > 0, b0 > 0};
         #1 chk("R3/R7/R8/R9 random", model_flt());
      end
      fault_clr = 1'b0;
      finish_run();
   end

endmodule